// File: doc/BRIEF.md
# Serial Peripheral Byte Exchanger with Contention Guard

This block moves one byte at a time over a four-wire synchronous serial link, in either the bus-driving role or the responding role. In the driving role, a write of the data byte starts an internal clock generator whose half period comes from a divider input. The byte goes out on the data-out line while a byte is collected from the data-in line. In the responding role, the clock comes from outside and the block shifts only while its select input is held low. A single control input chooses whether the lowest or the highest bit travels first.

The role bit is set by a one-cycle request and is cleared by hardware alone. If the select input goes low while the block holds the driving role, it gives up that role at once, so that two drivers never fight over the clock and data lines. Two sticky flags tell software what happened. One marks a finished exchange or a role loss. The other marks a data write that arrived during an exchange. Both are cleared by a status read that sees them set, followed by any data access.

Top module: `spi_port`

## Requirements
- R1: After reset the block is in the responding role (`mstr`=0), `busy`, `done_flag` and `wcol_flag` are 0, and `sck_o` is 0.
- R2: In the driving role, a data write while idle starts an exchange in which `sck_o` idles low and toggles every `div_sel`+1 clock cycles. `sck_o` stays 0 whenever the block is not in the driving role.
- R3: With `lsb_first`=1, bit 0 is sent and received first. With `lsb_first`=0, bit 7 goes first. Outgoing data changes after a falling clock edge, and incoming data is sampled on a rising edge.
- R4: A driving-role exchange sets `done_flag` exactly 16×(`div_sel`+1) cycles after the clock edge that takes the write, and `rx_data` then holds the byte received.
- R5: A data write while `busy` is 1 sets `wcol_flag` on that clock edge.
- R6: A write that collides leaves the byte being shifted unchanged, and that byte still goes out complete.
- R7: A `stat_rd` pulse that sees a flag set, followed later by a `dat_rd` or `dat_wr`, clears that flag. A data access without such a preceding status read leaves the flags set.
- R8: When `ss_n_i` is held low in the driving role, `mstr` drops to 0 on the third clock edge (two synchronizer stages, then the fault), not on the second. At the same edge the exchange is aborted, `busy` and `sck_o` go low, and `done_flag` is set.
- R9: In the responding role with `ss_n_i` high, `sck_i` edges are ignored, `busy` and `done_flag` stay 0, and `miso_o` is 0.
- R10: In the responding role with `ss_n_i` low, the byte loaded by an idle data write is presented on `miso_o` and advances after each falling edge of `sck_i`. `mosi_i` is sampled on each rising edge, and after eight bits `done_flag` sets with the byte in `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Block enable |
| mstr_set | input | 1 | One-cycle request to take the driving role |
| lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| div_sel | input | DIVW | Half period of the generated clock, minus one, in cycles |
| dat_wr | input | 1 | Data byte write strobe |
| dat_wdata | input | DW | Data byte to write |
| dat_rd | input | 1 | Data byte read strobe (for the flag clear sequence) |
| stat_rd | input | 1 | Status read strobe |
| ss_n_i | input | 1 | Select input, active low |
| sck_i | input | 1 | Serial clock from outside (responding role) |
| mosi_i | input | 1 | Serial data in (responding role) |
| miso_i | input | 1 | Serial data in (driving role) |
| sck_o | output | 1 | Generated serial clock (driving role) |
| mosi_o | output | 1 | Serial data out (driving role) |
| miso_o | output | 1 | Serial data out (responding role) |
| mstr | output | 1 | Role bit: 1 driving, 0 responding |
| busy | output | 1 | An exchange is in progress |
| done_flag | output | 1 | Exchange finished or role lost |
| wcol_flag | output | 1 | Data write during an exchange |
| rx_data | output | DW | Last byte received |

## Verification
In the driving role, the completion flag is due exactly 16×(`div_sel`+1) cycles after the edge that takes the write. The scoreboard stores that latency with each expected byte and compares it against a cycle counter when the flag rises. A role loss is due on the third edge after the select input falls, so the bench checks that the role bit is still 1 after the second edge and that the aborted state shows after the third. The collision flag is due on the edge that takes the offending write and is read half a cycle later. In the responding role, each `sck_i` edge takes effect three edges later. The bench therefore holds every level for eight cycles and reads `miso_o` just before it raises the clock.

// File: rtl/spi_pkg.sv
package spi_pkg;
  // per-cycle commands from the top-level sequencing to the shift datapath
  typedef struct packed {
    logic load;    // copy the written byte into the shift register
    logic start;   // begin a driving-role exchange
    logic sample;  // capture the incoming bit
    logic shift;   // advance to the next bit
    logic abort;   // drop any exchange in progress
  } shctl_t;
endpackage

// File: rtl/spi_sckgen.sv
module spi_sckgen #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            sck,
  output logic            rise,
  output logic            fall
);
  logic [DIVW-1:0] cnt_q, cnt_d;
  logic            sck_q, sck_d;
  logic            tick;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    tick  = 1'b0;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (cnt_q == div) begin
      tick  = 1'b1;
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + DIVW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck  = sck_q;
  assign rise = tick & ~sck_q;
  assign fall = tick & sck_q;

  // R2: the clock only rises while the generator was commanded to run
  a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> $past(run));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter import spi_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  shctl_t        ctl,
  input  logic [DW-1:0] ldata,
  input  logic          lsb_first,
  input  logic          sin,
  output logic          sout,
  output logic          act,
  output logic          done,
  output logic [DW-1:0] sreg,
  output logic [DW-1:0] rnext
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          samp_q, samp_d;
  logic          act_q, act_d;

  always_comb begin
    rnext = lsb_first ? {samp_q, sr_q[DW-1:1]} : {sr_q[DW-2:0], samp_q};
    done  = ctl.shift && act_q && !ctl.abort && (cnt_q == CW'(DW-1));
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    samp_d = samp_q;
    act_d  = act_q;
    if (ctl.load) sr_d = ldata;
    if (ctl.abort) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else begin
      if (ctl.start) begin
        act_d = 1'b1;
        cnt_d = '0;
      end
      if (ctl.sample) begin
        samp_d = sin;
        act_d  = 1'b1;
      end
      if (ctl.shift && act_q) begin
        sr_d  = rnext;
        cnt_d = done ? '0 : cnt_q + CW'(1);
        if (done) act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      samp_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      samp_q <= samp_d;
      act_q  <= act_d;
    end
  end

  assign sout = lsb_first ? sr_q[0] : sr_q[DW-1];
  assign act  = act_q;
  assign sreg = sr_q;

  // R4: completion always ends the busy state on the next edge
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !act_q);
endmodule

// File: rtl/spi_flags.sv
module spi_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic set_wcol,
  input  logic stat_rd,
  input  logic dat_acc,
  output logic done,
  output logic wcol
);
  logic done_q, done_d, wcol_q, wcol_d;
  logic arm_done_q, arm_done_d, arm_wcol_q, arm_wcol_d;

  always_comb begin
    arm_done_d = arm_done_q;
    arm_wcol_d = arm_wcol_q;
    if (dat_acc) begin
      arm_done_d = 1'b0;
      arm_wcol_d = 1'b0;
    end else if (stat_rd) begin
      arm_done_d = done_q;
      arm_wcol_d = wcol_q;
    end
    done_d = set_done | (done_q & ~(dat_acc & arm_done_q));
    wcol_d = set_wcol | (wcol_q & ~(dat_acc & arm_wcol_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      wcol_q     <= 1'b0;
      arm_done_q <= 1'b0;
      arm_wcol_q <= 1'b0;
    end else begin
      done_q     <= done_d;
      wcol_q     <= wcol_d;
      arm_done_q <= arm_done_d;
      arm_wcol_q <= arm_wcol_d;
    end
  end

  assign done = done_q;
  assign wcol = wcol_q;

  // R7: flags only fall on a data access
  a_r7_done_clear_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(dat_acc));
  a_r7_wcol_clear_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wcol_q) |-> $past(dat_acc));
endmodule

// File: rtl/spi_port.sv
module spi_port import spi_pkg::*; #(
  parameter int DW   = 8,
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            mstr_set,
  input  logic            lsb_first,
  input  logic [DIVW-1:0] div_sel,
  input  logic            dat_wr,
  input  logic [DW-1:0]   dat_wdata,
  input  logic            dat_rd,
  input  logic            stat_rd,
  input  logic            ss_n_i,
  input  logic            sck_i,
  input  logic            mosi_i,
  input  logic            miso_i,
  output logic            sck_o,
  output logic            mosi_o,
  output logic            miso_o,
  output logic            mstr,
  output logic            busy,
  output logic            done_flag,
  output logic            wcol_flag,
  output logic [DW-1:0]   rx_data
);
  logic [1:0]    rsync_q;
  logic          rst_q;
  logic [1:0]    ss_q;
  logic [2:0]    sckin_q;
  logic          mstr_q, mstr_d;
  logic [DW-1:0] rx_q, rx_d;
  logic          fault, sel, s_rise, s_fall, run;
  logic          m_rise, m_fall, gen_sck;
  logic          act, done_p, sout;
  logic [DW-1:0] sreg, rnext;
  shctl_t        ctl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ss_q    <= 2'b11;
      sckin_q <= 3'b000;
    end else begin
      ss_q    <= {ss_q[0], ss_n_i};
      sckin_q <= {sckin_q[1:0], sck_i};
    end
  end

  always_comb begin
    fault     = en && mstr_q && !ss_q[1];
    sel       = en && !mstr_q && !ss_q[1];
    s_rise    = sckin_q[1] & ~sckin_q[2];
    s_fall    = ~sckin_q[1] & sckin_q[2];
    run       = en && mstr_q && act && !fault;
    ctl.load  = dat_wr && en && !act;
    ctl.start = ctl.load && mstr_q && !fault;
    ctl.abort = fault || !en || (!mstr_q && ss_q[1]);
    ctl.sample = mstr_q ? m_rise : (sel && s_rise);
    ctl.shift  = mstr_q ? m_fall : (sel && s_fall);
    mstr_d = mstr_q;
    if (mstr_set) mstr_d = 1'b1;
    if (fault)    mstr_d = 1'b0;
    rx_d = done_p ? rnext : rx_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      mstr_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      mstr_q <= mstr_d;
      rx_q   <= rx_d;
    end
  end

  spi_sckgen #(.DIVW(DIVW)) u_sckgen (
    .clk(clk), .rst_n(rst_q), .run(run), .div(div_sel),
    .sck(gen_sck), .rise(m_rise), .fall(m_fall)
  );

  spi_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_q), .ctl(ctl), .ldata(dat_wdata),
    .lsb_first(lsb_first), .sin(mstr_q ? miso_i : mosi_i),
    .sout(sout), .act(act), .done(done_p), .sreg(sreg), .rnext(rnext)
  );

  spi_flags u_flags (
    .clk(clk), .rst_n(rst_q), .set_done(done_p | fault),
    .set_wcol(dat_wr && en && act), .stat_rd(stat_rd),
    .dat_acc(dat_wr | dat_rd), .done(done_flag), .wcol(wcol_flag)
  );

  assign sck_o   = gen_sck;
  assign mosi_o  = mstr_q ? sout : 1'b0;
  assign miso_o  = sel ? sout : 1'b0;
  assign mstr    = mstr_q;
  assign busy    = act;
  assign rx_data = rx_q;

  // R2: no generated clock outside the driving role
  a_r2_no_sck_unless_master: assert property (@(posedge clk) disable iff (!rst_q)
    !mstr_q |-> !sck_o);
  // R6: a colliding write leaves the shift register alone
  a_r6_collide_keeps_byte: assert property (@(posedge clk) disable iff (!rst_q)
    (dat_wr && act && !ctl.shift) |=> $stable(sreg));
  // R8: losing the role raises the done flag and stops the exchange
  a_r8_fault_sets_done: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(mstr_q) |-> (done_flag && !act));
endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  logic       clk = 1'b0;
  logic       rst_n, en, mstr_set, lsb_first, dat_wr, dat_rd, stat_rd;
  logic [3:0] div_sel;
  logic [7:0] dat_wdata;
  logic       ss_n_i, sck_i, mosi_i, miso_i;
  logic       sck_o, mosi_o, miso_o, mstr, busy, done_flag, wcol_flag;
  logic [7:0] rx_data;

  always #2 clk = ~clk;

  spi_port dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mstr_set(mstr_set), .lsb_first(lsb_first),
    .div_sel(div_sel), .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
    .stat_rd(stat_rd), .ss_n_i(ss_n_i), .sck_i(sck_i), .mosi_i(mosi_i),
    .miso_i(miso_i), .sck_o(sck_o), .mosi_o(mosi_o), .miso_o(miso_o),
    .mstr(mstr), .busy(busy), .done_flag(done_flag), .wcol_flag(wcol_flag),
    .rx_data(rx_data)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, t0 = 0;
  bit fin = 0;

  typedef struct {
    logic [7:0] rx;
    logic [7:0] tx;
    int         lat;
    bit         chk_rx;
    bit         chk_tx;
    bit         fault;
  } item_t;
  item_t q[$];

  // bench model of the far end while the block drives the link
  logic [7:0] slv_byte = 8'h00;
  int         fall_cnt = 0, fall_base = 0;
  logic [2:0] idx;
  logic [7:0] cap = 8'h00;
  assign idx    = 3'(fall_cnt - fall_base);
  assign miso_i = lsb_first ? slv_byte[idx] : slv_byte[3'd7 - idx];
  always @(negedge sck_o) fall_cnt <= fall_cnt + 1;
  always @(posedge sck_o) cap <= lsb_first ? {mosi_o, cap[7:1]} : {cap[6:0], mosi_o};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: pop an expectation on every rising edge of the done flag
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done_flag && !done_prev) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4", "unexpected done", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        if (it.fault) begin
          chk(cyc - t0 == it.lat, "R8", "fault latency", cyc - t0, it.lat);
          chk(mstr == 1'b0, "R8", "mstr after fault", mstr, 0);
          chk(busy == 1'b0, "R8", "busy after fault", busy, 0);
          chk(sck_o == 1'b0, "R8", "sck after fault", sck_o, 0);
        end else begin
          if (it.lat != 0)
            chk(cyc - t0 == it.lat, "R4", "done latency", cyc - t0, it.lat);
          if (it.chk_rx)
            chk(rx_data == it.rx, "R3,R4,R10", "rx byte", rx_data, it.rx);
          if (it.chk_tx)
            chk(cap == it.tx, "R3,R6", "sent byte", cap, it.tx);
        end
      end
    end
    done_prev <= done_flag;
  end

  task automatic clear_flags();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0; dat_rd = 1'b1;
    @(negedge clk) dat_rd = 1'b0;
    chk(done_flag == 1'b0, "R7", "done cleared", done_flag, 0);
    chk(wcol_flag == 1'b0, "R7", "wcol cleared", wcol_flag, 0);
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sb,
                             input int div, input bit lsb, input bit collide);
    item_t it;
    @(negedge clk);
    lsb_first = lsb; div_sel = 4'(div); slv_byte = sb; fall_base = fall_cnt;
    it.rx = sb; it.tx = tx; it.lat = 16 * (div + 1);
    it.chk_rx = 1'b1; it.chk_tx = 1'b1; it.fault = 1'b0;
    q.push_back(it);
    dat_wr = 1'b1; dat_wdata = tx;
    @(negedge clk) dat_wr = 1'b0; t0 = cyc;
    chk(busy == 1'b1, "R2", "busy after write", busy, 1);
    if (collide) begin
      repeat (5) @(negedge clk);
      dat_wr = 1'b1; dat_wdata = ~tx;
      @(negedge clk) dat_wr = 1'b0;
      chk(wcol_flag == 1'b1, "R5", "wcol on busy write", wcol_flag, 1);
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic slave_xfer(input bit do_load, input logic [7:0] tx,
                            input logic [7:0] rxb, input bit lsb);
    item_t it;
    @(negedge clk) lsb_first = lsb;
    if (do_load) begin
      dat_wr = 1'b1; dat_wdata = tx;
      @(negedge clk) dat_wr = 1'b0;
    end
    it.rx = rxb; it.tx = tx; it.lat = 0;
    it.chk_rx = 1'b1; it.chk_tx = 1'b0; it.fault = 1'b0;
    q.push_back(it);
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      mosi_i = lsb ? rxb[i] : rxb[7 - i];
      repeat (8) @(negedge clk);
      chk(miso_o == (lsb ? tx[i] : tx[7 - i]), "R10", "miso bit", miso_o,
          lsb ? tx[i] : tx[7 - i]);
      if (i == 0) chk(sck_o == 1'b0, "R2", "sck in responding role", sck_o, 0);
      sck_i = 1'b1; repeat (8) @(negedge clk);
      sck_i = 1'b0; repeat (8) @(negedge clk);
    end
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; mstr_set = 1'b0; lsb_first = 1'b0; div_sel = 4'd0;
    dat_wr = 1'b0; dat_wdata = 8'h00; dat_rd = 1'b0; stat_rd = 1'b0;
    ss_n_i = 1'b1; sck_i = 1'b0; mosi_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mstr == 1'b0, "R1", "mstr reset", mstr, 0);
    chk(busy == 1'b0, "R1", "busy reset", busy, 0);
    chk(done_flag == 1'b0, "R1", "done reset", done_flag, 0);
    chk(wcol_flag == 1'b0, "R1", "wcol reset", wcol_flag, 0);
    chk(sck_o == 1'b0, "R1", "sck reset", sck_o, 0);

    en = 1'b1;
    @(negedge clk) mstr_set = 1'b1;
    @(negedge clk) mstr_set = 1'b0;
    chk(mstr == 1'b1, "R2", "mstr set", mstr, 1);

    // R3 R4: MSB first, fastest clock
    master_xfer(8'hA5, 8'h3C, 0, 1'b0, 1'b0);
    clear_flags();
    // R3 R4: LSB first, slower clock
    master_xfer(8'h81, 8'h6E, 2, 1'b1, 1'b0);
    // R7: data access without status read keeps the flag
    @(negedge clk) dat_rd = 1'b1;
    @(negedge clk) dat_rd = 1'b0;
    chk(done_flag == 1'b1, "R7", "done kept without status read", done_flag, 1);
    clear_flags();

    // R5 R6: collision during an exchange
    master_xfer(8'h4B, 8'hD2, 1, 1'b0, 1'b1);
    chk(wcol_flag == 1'b1, "R5", "wcol held", wcol_flag, 1);
    clear_flags();

    // R8: role loss while idle
    begin
      item_t it;
      it.rx = 8'h00; it.tx = 8'h00; it.lat = 3;
      it.chk_rx = 1'b0; it.chk_tx = 1'b0; it.fault = 1'b1;
      @(negedge clk);
      q.push_back(it);
      ss_n_i = 1'b0; t0 = cyc;
      repeat (2) @(negedge clk);
      chk(mstr == 1'b1, "R8", "mstr kept two edges", mstr, 1);
      repeat (3) @(negedge clk);
      ss_n_i = 1'b1;
      repeat (3) @(negedge clk);
    end
    clear_flags();

    // R8: role loss during an exchange
    @(negedge clk) mstr_set = 1'b1;
    @(negedge clk) mstr_set = 1'b0; div_sel = 4'd3; lsb_first = 1'b0;
    dat_wr = 1'b1; dat_wdata = 8'hF0;
    @(negedge clk) dat_wr = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R8", "busy before fault", busy, 1);
    begin
      item_t it;
      it.rx = 8'h00; it.tx = 8'h00; it.lat = 3;
      it.chk_rx = 1'b0; it.chk_tx = 1'b0; it.fault = 1'b1;
      q.push_back(it);
      ss_n_i = 1'b0; t0 = cyc;
    end
    repeat (5) @(negedge clk);
    chk(sck_o == 1'b0, "R8", "sck stopped", sck_o, 0);
    ss_n_i = 1'b1;
    repeat (3) @(negedge clk);
    clear_flags();

    // R9: responding role, deselected clocks ignored
    @(negedge clk) lsb_first = 1'b0; dat_wr = 1'b1; dat_wdata = 8'hC3;
    @(negedge clk) dat_wr = 1'b0;
    for (int k = 0; k < 8; k++) begin
      sck_i = 1'b1; repeat (4) @(negedge clk);
      sck_i = 1'b0; repeat (4) @(negedge clk);
    end
    chk(done_flag == 1'b0, "R9", "done while deselected", done_flag, 0);
    chk(busy == 1'b0, "R9", "busy while deselected", busy, 0);
    chk(miso_o == 1'b0, "R9", "miso while deselected", miso_o, 0);
    chk(wcol_flag == 1'b0, "R9", "no wcol on idle load", wcol_flag, 0);

    // R10: exchanges clocked from outside
    slave_xfer(1'b0, 8'hC3, 8'h5A, 1'b0);
    clear_flags();
    slave_xfer(1'b1, 8'h96, 8'h3D, 1'b1);
    clear_flags();

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R4", "pending expectations", q.size(), 0);
    fin = 1'b1;
    summary();
    $finish;
  end
endmodule